// File: doc/BRIEF.md
# Command/Address Parity Guard

This block sits on the receiving side of a DDR4-style command/address bus. On every rising clock edge it samples chip select, the activate strobe, the three shared command/address lines, the bank-group and bank bits, the low address bits and a parity bit.

When checking is switched on and chip select is low, it tests even parity across all covered bits. A command that passes is forwarded downstream as one registered word. A command that fails drives the active-low alert output low for a recovery window of `REC_CYCLES` clocks, and is not forwarded. A sticky status bit records that such an error occurred.

Commands that arrive while the recovery window is open are dropped without being checked. A separate write-CRC error input does not start a recovery window. It only produces an alert pulse of `CRC_PULSE` clocks. When a CRC pulse and a recovery window overlap, the alert stays low until both have finished.

Top module: `ca_parity_guard`

## Requirements
- R1: The covered word is {actN, cmdLines[2:0], bankGroup[1:0], bankAddr[1:0], addr[ADDR_W-1:0]}. A selected command is a parity error when the XOR of that word and parityIn is 1. With checking enabled, such a command drives alertN low from the second rising edge after the edge that sampled it.
- R2: While parityEnable is 0 at the sampling edge, no parity error is ever reported. The command is forwarded even when its parity is wrong.
- R3: A cycle with csN high is ignored. Nothing is forwarded, no error is raised and the alert does not change.
- R4: After a parity error, alertN stays low for exactly REC_CYCLES clocks and then returns high by itself.
- R5: The failing command is not forwarded. Every command sampled during the following REC_CYCLES edges is dropped unchecked. The command sampled on the next edge after those is handled normally.
- R6: A command accepted at edge E appears at the second edge after E. For that one cycle fwdValid is 1, and fwdBus holds the covered word in the R1 bit order, with actN as the most significant bit.
- R7: errSticky is set on the edge that starts a recovery and holds until an edge that samples errClear high. A new error on that same edge wins over the clear.
- R8: A crcErr sampled high at edge E drives alertN low for exactly CRC_PULSE clocks starting after E. It does not block commands and does not set errSticky.
- R9: When a CRC pulse and a parity recovery overlap, alertN stays low until the later of the two has ended.
- R10: After reset, alertN is 1 and fwdValid and errSticky are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| parityEnable | input | 1 | Mode bit that enables parity checking |
| csN | input | 1 | Chip select, active low |
| actN | input | 1 | Activate strobe, active low |
| cmdLines | input | 3 | Shared command/address lines (address bits 16..14) |
| bankGroup | input | 2 | Bank group address |
| bankAddr | input | 2 | Bank address |
| addr | input | ADDR_W | Low address bits |
| parityIn | input | 1 | Even-parity bit for the covered word |
| crcErr | input | 1 | Write-CRC error request |
| errClear | input | 1 | Clears the sticky error bit |
| alertN | output | 1 | Alert, active low, idles high |
| fwdValid | output | 1 | Forwarded command valid |
| fwdBus | output | ADDR_W+8 | Forwarded covered word |
| errSticky | output | 1 | Sticky parity-error flag |

## Verification
Let the sampling edge of a command be E. The forwarded word and a parity alert are due at E+2. A CRC alert is due at E+1. The sticky clear takes effect at E+1.

Recovery lasts REC_CYCLES, so the alert is low at E+2 through E+REC_CYCLES+1. Commands sampled at E+1 through E+REC_CYCLES are dropped, and the command sampled at E+REC_CYCLES+1 is forwarded at E+REC_CYCLES+3.

The bench drives inputs on falling edges. It counts falling edges from the stimulus and compares outputs only on the falling edge where each result is due, so every check reads settled values exactly one edge count after its cause.

// File: rtl/ca_parity_pkg.sv
package ca_parity_pkg;

  // Status the datapath reports about the command captured at the last edge
  typedef struct packed {
    logic valid;    // a selected command was captured
    logic parErr;   // that command failed the enabled parity check
  } capStat_t;

  // Strobes the control issues back to the datapath
  typedef struct packed {
    logic fwdLoad;  // forward the captured command
    logic errTake;  // the captured command starts a recovery
  } ctrlStrobe_t;

endpackage

// File: rtl/ca_parity_datapath.sv
module ca_parity_datapath
  import ca_parity_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              parityEnable,
  input  logic              csN,
  input  logic              actN,
  input  logic [2:0]        cmdLines,
  input  logic [1:0]        bankGroup,
  input  logic [1:0]        bankAddr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              parityIn,
  input  ctrlStrobe_t       strobe,
  output capStat_t          stat,
  output logic              fwdValid,
  output logic [ADDR_W+7:0] fwdBus
);

  localparam int BUS_W = ADDR_W + 8;

  logic [BUS_W-1:0] covered;
  logic [BUS_W:0]   chain;
  logic [BUS_W-1:0] capBus;
  logic             capValid;
  logic             capErr;

  assign covered = {actN, cmdLines, bankGroup, bankAddr, addr};

  // Serial XOR chain, seeded with the parity input
  assign chain[0] = parityIn;
  for (genvar i = 0; i < BUS_W; i++) begin : g_par
    assign chain[i+1] = chain[i] ^ covered[i];
  end

  // First stage: capture the command and its parity verdict
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValid <= 1'b0;
      capErr   <= 1'b0;
      capBus   <= '0;
    end else begin
      capValid <= ~csN;
      capErr   <= ~csN & parityEnable & chain[BUS_W];
      if (!csN) capBus <= covered;
    end
  end

  assign stat.valid  = capValid;
  assign stat.parErr = capErr;

  // Second stage: forward only when the control accepts the command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdValid <= 1'b0;
      fwdBus   <= '0;
    end else begin
      fwdValid <= strobe.fwdLoad;
      if (strobe.fwdLoad) fwdBus <= capBus;
    end
  end

endmodule

// File: rtl/ca_parity_ctrl.sv
module ca_parity_ctrl
  import ca_parity_pkg::*;
#(
  parameter int REC_CYCLES = 8,
  parameter int CRC_PULSE  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  capStat_t    stat,
  input  logic        crcErr,
  input  logic        errClear,
  output ctrlStrobe_t strobe,
  output logic        alertN,
  output logic        errSticky
);

  localparam int REC_W = $clog2(REC_CYCLES + 1);
  localparam int CRC_W = $clog2(CRC_PULSE + 1);

  logic [REC_W-1:0] recCount;
  logic [CRC_W-1:0] crcCount;
  logic             recBusy;
  logic             crcBusy;

  assign recBusy = (recCount != '0);
  assign crcBusy = (crcCount != '0);

  // Commands are neither checked nor forwarded while a recovery runs
  assign strobe.errTake = stat.valid & stat.parErr & ~recBusy;
  assign strobe.fwdLoad = stat.valid & ~stat.parErr & ~recBusy;

  // Parity recovery window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recCount <= '0;
    end else if (strobe.errTake) begin
      recCount <= REC_W'(REC_CYCLES);
    end else if (recBusy) begin
      recCount <= recCount - 1'b1;
    end
  end

  // Fixed-width CRC alert pulse (a new request restarts it)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcCount <= '0;
    end else if (crcErr) begin
      crcCount <= CRC_W'(CRC_PULSE);
    end else if (crcBusy) begin
      crcCount <= crcCount - 1'b1;
    end
  end

  // Sticky flag: a new error wins over a clear on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errSticky <= 1'b0;
    end else if (strobe.errTake) begin
      errSticky <= 1'b1;
    end else if (errClear) begin
      errSticky <= 1'b0;
    end
  end

  assign alertN = ~(recBusy | crcBusy);

endmodule

// File: rtl/ca_parity_guard.sv
module ca_parity_guard
  import ca_parity_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int REC_CYCLES = 8,
  parameter int CRC_PULSE  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              parityEnable,
  input  logic              csN,
  input  logic              actN,
  input  logic [2:0]        cmdLines,
  input  logic [1:0]        bankGroup,
  input  logic [1:0]        bankAddr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              parityIn,
  input  logic              crcErr,
  input  logic              errClear,
  output logic              alertN,
  output logic              fwdValid,
  output logic [ADDR_W+7:0] fwdBus,
  output logic              errSticky
);

  capStat_t    stat;
  ctrlStrobe_t strobe;

  ca_parity_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .parityEnable(parityEnable), .csN(csN),
    .actN(actN), .cmdLines(cmdLines), .bankGroup(bankGroup),
    .bankAddr(bankAddr), .addr(addr), .parityIn(parityIn),
    .strobe(strobe), .stat(stat), .fwdValid(fwdValid), .fwdBus(fwdBus)
  );

  ca_parity_ctrl #(.REC_CYCLES(REC_CYCLES), .CRC_PULSE(CRC_PULSE)) u_ctrl (
    .clk(clk), .rstN(rstN), .stat(stat), .crcErr(crcErr),
    .errClear(errClear), .strobe(strobe), .alertN(alertN),
    .errSticky(errSticky)
  );

endmodule

// File: rtl/ca_parity_checker.sv
module ca_parity_checker (
  input logic clk,
  input logic rstN,
  input logic parityEnable,
  input logic csN,
  input logic crcErr,
  input logic errClear,
  input logic alertN,
  input logic fwdValid,
  input logic errSticky
);

  // R3: an unselected cycle never yields a forwarded command
  assert_cs_high_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> ##2 !fwdValid);

  // R2: checking disabled at sampling means no error is recorded
  assert_disabled_no_error_R2: assert property (@(posedge clk) disable iff (!rstN)
    !parityEnable |-> ##2 !$rose(errSticky));

  // R1: a recorded error coincides with the alert being low
  assert_error_alerts_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errSticky) |-> !alertN);

  // R7: the sticky flag holds until a clear is sampled
  assert_sticky_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (errSticky && !errClear) |=> errSticky);

  // R8: a CRC request pulls the alert low on the next cycle
  assert_crc_alerts_R8: assert property (@(posedge clk) disable iff (!rstN)
    crcErr |=> !alertN);

endmodule

bind ca_parity_guard ca_parity_checker u_chk (
  .clk(clk), .rstN(rstN), .parityEnable(parityEnable), .csN(csN),
  .crcErr(crcErr), .errClear(errClear), .alertN(alertN),
  .fwdValid(fwdValid), .errSticky(errSticky)
);

// File: tb/ca_parity_guard_bench.sv
module ca_parity_guard_bench;

  localparam int ADDR_W = 14;
  localparam int REC    = 8;
  localparam int CRCP   = 4;
  localparam int BUS_W  = ADDR_W + 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic parityEnable = 1'b1;
  logic csN = 1'b1;
  logic actN = 1'b1;
  logic [2:0] cmdLines = '0;
  logic [1:0] bankGroup = '0;
  logic [1:0] bankAddr = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic parityIn = 1'b0;
  logic crcErr = 1'b0;
  logic errClear = 1'b0;
  logic alertN;
  logic fwdValid;
  logic [BUS_W-1:0] fwdBus;
  logic errSticky;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ca_parity_guard #(.ADDR_W(ADDR_W), .REC_CYCLES(REC), .CRC_PULSE(CRCP)) u_ca_parity_guard (
    .clk(clk), .rstN(rstN), .parityEnable(parityEnable), .csN(csN),
    .actN(actN), .cmdLines(cmdLines), .bankGroup(bankGroup),
    .bankAddr(bankAddr), .addr(addr), .parityIn(parityIn),
    .crcErr(crcErr), .errClear(errClear), .alertN(alertN),
    .fwdValid(fwdValid), .fwdBus(fwdBus), .errSticky(errSticky)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [BUS_W-1:0] word, input bit bad);
    csN = 1'b0;
    {actN, cmdLines, bankGroup, bankAddr, addr} = word;
    parityIn = (^word) ^ bad;
  endtask

  task automatic idle();
    csN = 1'b1;
    parityIn = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tReset();
    check(alertN === 1'b1, "R10 alertN", alertN, 1);
    check(fwdValid === 1'b0, "R10 fwdValid", fwdValid, 0);
    check(errSticky === 1'b0, "R10 errSticky", errSticky, 0);
  endtask

  task automatic tForward();
    logic [BUS_W-1:0] words [4];
    words[0] = 22'h3FFFFF; words[1] = 22'h000001;
    words[2] = 22'h2A5A5A; words[3] = 22'h15C3A6;
    for (int w = 0; w < 4; w++) begin
      drive(words[w], 0);
      tick(1); idle(); tick(1);
      check(fwdValid === 1'b1, "R6 fwdValid", fwdValid, 1);
      check(fwdBus === words[w], "R6 fwdBus", fwdBus, words[w]);
      check(alertN === 1'b1, "R1 no alert on good parity", alertN, 1);
      tick(1);
      check(fwdValid === 1'b0, "R6 single cycle", fwdValid, 0);
    end
  endtask

  task automatic tCsHigh();
    csN = 1'b1;
    {actN, cmdLines, bankGroup, bankAddr, addr} = 22'h123456;
    parityIn = ~(^22'h123456);
    tick(2);
    check(fwdValid === 1'b0, "R3 no forward", fwdValid, 0);
    check(alertN === 1'b1, "R3 no alert", alertN, 1);
    check(errSticky === 1'b0, "R3 no sticky", errSticky, 0);
    idle();
  endtask

  task automatic tDisabled();
    parityEnable = 1'b0;
    drive(22'h0F0F0F, 1);
    tick(1); idle(); parityEnable = 1'b1; tick(1);
    check(fwdValid === 1'b1, "R2 forwarded", fwdValid, 1);
    check(fwdBus === 22'h0F0F0F, "R2 word", fwdBus, 22'h0F0F0F);
    check(alertN === 1'b1, "R2 no alert", alertN, 1);
    tick(1);
    check(errSticky === 1'b0, "R2 no sticky", errSticky, 0);
  endtask

  task automatic tRecovery();
    // Error driven at N0; good commands driven at N1..N(REC+1)
    drive(22'h1ABCDE, 1);
    for (int k = 1; k <= REC + 3; k++) begin
      tick(1);
      if (k == 1) check(alertN === 1'b1, "R1 alert not yet", alertN, 1);
      else if (k <= REC + 1) check(alertN === 1'b0, "R4 alert low", alertN, 0);
      else check(alertN === 1'b1, "R4 alert released", alertN, 1);
      if (k >= 2) begin
        if (k == REC + 3) check(fwdValid === 1'b1, "R5 first command after window", fwdValid, 1);
        else check(fwdValid === 1'b0, "R5 dropped", fwdValid, 0);
      end
      if (k == 2) check(errSticky === 1'b1, "R7 sticky set", errSticky, 1);
      if (k <= REC + 1) drive(22'h000100 + 22'(k), 0);
      else idle();
    end
    check(fwdBus === 22'h000100 + 22'(REC + 1), "R5 word", fwdBus, 22'h000100 + 22'(REC + 1));
  endtask

  task automatic tClear();
    tick(2);
    check(errSticky === 1'b1, "R7 holds", errSticky, 1);
    errClear = 1'b1; tick(1); errClear = 1'b0;
    check(errSticky === 1'b0, "R7 cleared", errSticky, 0);
    // Error and clear on the same edge: the error wins
    drive(22'h222222, 1); tick(1); idle(); errClear = 1'b1; tick(1); errClear = 1'b0;
    check(errSticky === 1'b1, "R7 set beats clear", errSticky, 1);
    tick(REC + 2);
    check(alertN === 1'b1, "R4 idle again", alertN, 1);
  endtask

  task automatic tCrc();
    crcErr = 1'b1;
    drive(22'h055555, 0);
    tick(1); crcErr = 1'b0; idle();
    for (int k = 1; k <= CRCP + 1; k++) begin
      if (k <= CRCP) check(alertN === 1'b0, "R8 pulse low", alertN, 0);
      else check(alertN === 1'b1, "R8 pulse ended", alertN, 1);
      if (k == 1) begin
        tick(1);
        k++;
        check(fwdValid === 1'b1, "R8 no blocking", fwdValid, 1);
        if (k <= CRCP) check(alertN === 1'b0, "R8 pulse low", alertN, 0);
      end
      tick(1);
    end
  endtask

  task automatic tOverlap();
    drive(22'h333333, 1);
    for (int k = 1; k <= REC + CRCP + 1; k++) begin
      tick(1);
      idle();
      if (k >= 2 && k <= REC + CRCP) check(alertN === 1'b0, "R9 alert held", alertN, 0);
      if (k == REC + CRCP + 1) check(alertN === 1'b1, "R9 alert released", alertN, 1);
      crcErr = (k == REC);
    end
    crcErr = 1'b0;
  endtask

  initial begin
    tick(2);
    tReset();
    rstN = 1'b1;
    tick(1);
    tReset();
    tForward();
    tCsHigh();
    tDisabled();
    tRecovery();
    tClear();
    tCrc();
    tick(2);
    tOverlap();
    tick(2);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule